// File: doc/BRIEF.md
# Renormalisation-Rate Node Sync Monitor

This block decides whether a convolutional decoder has lost node synchronisation by watching how often its path metrics renormalise. A decoder that is locked renormalises rarely. A decoder fed with misaligned symbol pairs renormalises often. The block counts renormalisation strobes over a programmable observation window, measured in decoded bits. If the count passes a programmable threshold inside one window, it declares loss of sync.

Each declaration raises a level flag and emits a single-cycle correction pulse. The pulse is intended to be looped back to the symbol-pairing logic of the front end, which then shifts its alignment. The flag stays up until a complete window passes with no declaration.

The window parameter and the threshold parameter are taken from one of two sources. They come from input pins when the source-select input is high. They come from two host-written registers when it is low.

Top module: `nsm_monitor`

## Requirements
- R1: After reset both outputs are low. Both host registers are zero, so with the source select low the window is 256 bits and the threshold is 6.
- R2: An 8-bit window value W gives an observation window of 256*(W+1) cycles in which `bit_vld` is high. Cycles with `bit_vld` low do not advance the window.
- R3: An 8-bit threshold value T gives a limit of 8*T+6 events. The event that takes the count inside the current window above that limit is a declaration.
- R4: A declaration sets `oos_flag` and drives `corr_pulse` high for exactly one cycle. Both appear after the clock edge that samples the offending strobe.
- R5: `oos_flag` clears on the edge that samples the last valid bit of a window without a declaration, and at no other time.
- R6: When `ext_sel` is 1, the window and threshold come from `pin_win` and `pin_thr`. When it is 0, they come from host registers. Address 0 holds the window value and address 1 holds the threshold value. Both are written through `host_we`, `host_addr` and `host_wdata`, and take effect from the next cycle.
- R7: A declaration restarts both the window and the event count at once, so at most one declaration occurs per window. Strobes after it count toward the next window only.
- R8: If a declaration and the last valid bit of a window fall in the same cycle, the declaration takes priority: the flag is set, the pulse is emitted, and both counts restart.
- R9: Renormalisation strobes are counted whether or not `bit_vld` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | One decoded bit delivered this cycle |
| renorm_stb | input | 1 | Path-metric renormalisation occurred this cycle |
| ext_sel | input | 1 | 1: parameters from pins, 0: from host registers |
| pin_win | input | 8 | Window value from pins |
| pin_thr | input | 8 | Threshold value from pins |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 1 | Host register address (0 window, 1 threshold) |
| host_wdata | input | 8 | Host register write data |
| oos_flag | output | 1 | Out-of-sync level flag |
| corr_pulse | output | 1 | One-cycle correction pulse per declaration |

## Verification
The hardest case to reach is a declaration that lands on the very cycle that ends a window. This needs the last valid bit and the strobe that exceeds the threshold to arrive together. Random traffic almost never produces it. The stimulus therefore drives a directed sequence that counts out 255 clean valid bits, then sends six strobes with `bit_vld` low, then sends one cycle with both inputs high. The clean-window release of the flag needs a run with no excess events and is also forced by a directed sequence. Random segments with low strobe rates then cover the release again under varied parameters.

// File: rtl/nsm_pkg.sv
package nsm_pkg;

   // source of the window/threshold parameters
   typedef enum logic {
      NSM_SRC_REGS = 1'b0,
      NSM_SRC_PINS = 1'b1
   } nsm_src_e;

   // host register indices (behaviour depends on these)
   localparam int unsigned NSM_REG_WIN = 0;
   localparam int unsigned NSM_REG_THR = 1;
   localparam int unsigned NSM_NUM_REGS = 2;

   function automatic int unsigned nsm_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/nsm_cfg_regs.sv
module nsm_cfg_regs
   import nsm_pkg::*;
#(
   parameter int unsigned WIN_W = 8,
   parameter int unsigned THR_W = 8,
   parameter int unsigned AW    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [AW-1:0]    host_addr,
   input  logic [nsm_max(WIN_W, THR_W)-1:0] host_wdata,
   input  logic             ext_sel,
   input  logic [WIN_W-1:0] pin_win,
   input  logic [THR_W-1:0] pin_thr,
   output logic [WIN_W-1:0] win_n,
   output logic [THR_W-1:0] thr_n
);
   localparam int unsigned DW = nsm_max(WIN_W, THR_W);

   initial begin
      assert ((1 << AW) >= NSM_NUM_REGS)
         else $error("nsm_cfg_regs: AW too small for register set");
   end

   logic [DW-1:0] regs_q [NSM_NUM_REGS];

   for (genvar gi = 0; gi < NSM_NUM_REGS; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[gi] <= '0;
         end else if (host_we && (host_addr == AW'(gi))) begin
            regs_q[gi] <= host_wdata;
         end
      end
   end

   nsm_src_e src;
   assign src = nsm_src_e'(ext_sel);

   always_comb begin
      if (src == NSM_SRC_PINS) begin
         win_n = pin_win;
         thr_n = pin_thr;
      end else begin
         win_n = regs_q[NSM_REG_WIN][WIN_W-1:0];
         thr_n = regs_q[NSM_REG_THR][THR_W-1:0];
      end
   end

endmodule

// File: rtl/nsm_window_ctr.sv
module nsm_window_ctr #(
   parameter int unsigned WIN_W     = 8,
   parameter int unsigned WIN_SHIFT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic [WIN_W-1:0] win_n,
   input  logic             restart,
   output logic             period_end
);
   localparam int unsigned CW = WIN_W + WIN_SHIFT;

   initial begin
      assert (WIN_W > 0 && WIN_SHIFT > 0 && CW <= 31)
         else $error("nsm_window_ctr: bad window geometry");
   end

   logic [CW-1:0] bcnt_q;
   logic [CW-1:0] last_idx;

   // window length (N+1) << SHIFT, last index = (N << SHIFT) | ones
   assign last_idx   = {win_n, {WIN_SHIFT{1'b1}}};
   assign period_end = bit_vld && (bcnt_q >= last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt_q <= '0;
      end else if (restart) begin
         bcnt_q <= '0;
      end else if (bit_vld) begin
         bcnt_q <= bcnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/nsm_event_ctr.sv
module nsm_event_ctr #(
   parameter int unsigned THR_W     = 8,
   parameter int unsigned THR_SHIFT = 3,
   parameter int unsigned THR_OFS   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             renorm_stb,
   input  logic [THR_W-1:0] thr_n,
   input  logic             restart,
   output logic             declare
);
   localparam int unsigned EW = THR_W + THR_SHIFT + 1;

   initial begin
      assert (THR_OFS < (1 << THR_SHIFT))
         else $error("nsm_event_ctr: offset does not fit below scale");
      assert (THR_OFS >= 1)
         else $error("nsm_event_ctr: offset must keep declarations apart");
   end

   logic [EW-1:0] ecnt_q;
   logic [EW-1:0] limit;

   assign limit   = (EW'(thr_n) << THR_SHIFT) + EW'(THR_OFS);
   // strobe number ecnt_q+1 exceeds the limit
   assign declare = renorm_stb && (ecnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt_q <= '0;
      end else if (restart) begin
         ecnt_q <= '0;
      end else if (renorm_stb) begin
         ecnt_q <= ecnt_q + 1'b1;
      end
   end

   AST_DECL_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      declare |-> (ecnt_q >= EW'(THR_OFS)));                    // R3

endmodule

// File: rtl/nsm_monitor.sv
module nsm_monitor #(
   parameter int unsigned WIN_W     = 8,
   parameter int unsigned WIN_SHIFT = 8,
   parameter int unsigned THR_W     = 8,
   parameter int unsigned THR_SHIFT = 3,
   parameter int unsigned THR_OFS   = 6,
   parameter int unsigned AW        = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             renorm_stb,
   input  logic             ext_sel,
   input  logic [WIN_W-1:0] pin_win,
   input  logic [THR_W-1:0] pin_thr,
   input  logic             host_we,
   input  logic [AW-1:0]    host_addr,
   input  logic [nsm_pkg::nsm_max(WIN_W, THR_W)-1:0] host_wdata,
   output logic             oos_flag,
   output logic             corr_pulse
);
   logic [WIN_W-1:0] win_n;
   logic [THR_W-1:0] thr_n;
   logic             period_end;
   logic             declare;
   logic             restart;

   nsm_cfg_regs #(.WIN_W(WIN_W), .THR_W(THR_W), .AW(AW)) i_cfg (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .ext_sel(ext_sel), .pin_win(pin_win), .pin_thr(pin_thr),
      .win_n(win_n), .thr_n(thr_n)
   );

   nsm_window_ctr #(.WIN_W(WIN_W), .WIN_SHIFT(WIN_SHIFT)) i_win (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .win_n(win_n),
      .restart(restart), .period_end(period_end)
   );

   nsm_event_ctr #(.THR_W(THR_W), .THR_SHIFT(THR_SHIFT), .THR_OFS(THR_OFS)) i_evt (
      .clk(clk), .rst_n(rst_n), .renorm_stb(renorm_stb), .thr_n(thr_n),
      .restart(restart), .declare(declare)
   );

   assign restart = declare || period_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oos_flag   <= 1'b0;
         corr_pulse <= 1'b0;
      end else begin
         corr_pulse <= declare;
         if (declare) begin
            oos_flag <= 1'b1;          // declaration wins over window end
         end else if (period_end) begin
            oos_flag <= 1'b0;
         end
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      corr_pulse |=> !corr_pulse);                              // R4
   AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      corr_pulse |-> oos_flag);                                 // R4
   AST_FLAG_RISE_PULSED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oos_flag) |-> corr_pulse);                          // R5
   AST_FLAG_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oos_flag) |-> ($past(period_end) && !corr_pulse));  // R5
   AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && !declare) |=> !oos_flag);                  // R8

endmodule

// File: tb/test_nsm_monitor.sv
module test_nsm_monitor;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_vld = 1'b0, renorm_stb = 1'b0, ext_sel = 1'b0;
   logic [7:0] pin_win = '0, pin_thr = '0;
   logic       host_we = 1'b0;
   logic [0:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic       oos_flag, corr_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference state
   int  m_bcnt = 0, m_ecnt = 0;
   bit  m_oos = 0, m_pulse = 0;
   int  m_reg_win = 0, m_reg_thr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nsm_monitor i_nsm_monitor (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .renorm_stb(renorm_stb),
      .ext_sel(ext_sel), .pin_win(pin_win), .pin_thr(pin_thr),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .oos_flag(oos_flag), .corr_pulse(corr_pulse)
   );

   function automatic int win_len(input int n);
      return 256 * (n + 1);          // R2
   endfunction
   function automatic int thr_lim(input int n);
      return 8 * n + 6;              // R3
   endfunction

   task automatic check(input bit cond, input string req, input int act, input int exp);
      n_cmp++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: inputs driven now (at negedge), compared at the next negedge
   task automatic cycle(input bit vld, input bit stb);
      int  wn, tn;
      bit  decl, pend;
      bit_vld    = vld;
      renorm_stb = stb;
      wn   = ext_sel ? int'(pin_win) : m_reg_win;
      tn   = ext_sel ? int'(pin_thr) : m_reg_thr;
      decl = stb && (m_ecnt + 1 > thr_lim(tn));
      pend = vld && (m_bcnt + 1 >= win_len(wn));
      if (decl) begin
         m_bcnt = 0; m_ecnt = 0; m_oos = 1; m_pulse = 1;   // R7 R8
      end else begin
         m_pulse = 0;
         if (pend) begin
            m_bcnt = 0; m_ecnt = 0; m_oos = 0;
         end else begin
            m_bcnt += int'(vld);
            m_ecnt += int'(stb);                          // R9
         end
      end
      if (host_we) begin
         if (host_addr == 1'b0) m_reg_win = int'(host_wdata);
         else                   m_reg_thr = int'(host_wdata);
      end
      @(posedge clk);
      @(negedge clk);
      host_we = 1'b0;
      check(corr_pulse == m_pulse, "R4 corr_pulse", int'(corr_pulse), int'(m_pulse));
      check(oos_flag == m_oos, "R5 oos_flag", int'(oos_flag), int'(m_oos));
   endtask

   task automatic host_write(input bit addr, input int val);
      host_we    = 1'b1;
      host_addr  = addr;
      host_wdata = 8'(val);
      cycle(1'b0, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(oos_flag == 1'b0 && corr_pulse == 1'b0, "R1 reset outputs",
            int'({oos_flag, corr_pulse}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R3: default registers -> limit 6; six strobes are fine
      for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1);
      check(oos_flag == 1'b0, "R1 six strobes under default limit", int'(oos_flag), 0);
      // R9: seventh strobe with no valid bits declares
      cycle(1'b0, 1'b1);
      check(corr_pulse == 1'b1, "R3 R9 declaration on 7th strobe", int'(corr_pulse), 1);
      check(oos_flag == 1'b1, "R4 flag set", int'(oos_flag), 1);
      cycle(1'b0, 1'b0);
      check(corr_pulse == 1'b0, "R4 pulse one cycle", int'(corr_pulse), 0);

      // R7: counts restarted, six more strobes do not declare
      for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1);
      check(corr_pulse == 1'b0 && oos_flag == 1'b1, "R7 restart after declaration",
            int'({oos_flag, corr_pulse}), 2);
      // finish the window: 255 bits keeps the flag, the 256th clears it
      for (int i = 0; i < 255; i++) cycle(1'b1, 1'b0);
      check(oos_flag == 1'b1, "R2 window not yet complete", int'(oos_flag), 1);
      cycle(1'b1, 1'b0);
      check(oos_flag == 1'b0, "R5 clean window clears flag", int'(oos_flag), 0);

      // R8: declaration on the last bit of a window
      for (int i = 0; i < 255; i++) cycle(1'b1, 1'b0);
      for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1);
      cycle(1'b1, 1'b1);
      check(corr_pulse == 1'b1 && oos_flag == 1'b1, "R8 declaration wins at window end",
            int'({oos_flag, corr_pulse}), 3);
      for (int i = 0; i < 256; i++) cycle(1'b1, 1'b0);
      check(oos_flag == 1'b0, "R8 counts restarted at coincidence", int'(oos_flag), 0);

      // R6: host registers, window 512 and limit 14
      host_write(1'b0, 1);
      host_write(1'b1, 1);
      for (int i = 0; i < 14; i++) cycle(1'b0, 1'b1);
      check(corr_pulse == 1'b0, "R6 register limit 14 respected", int'(corr_pulse), 0);
      cycle(1'b0, 1'b1);
      check(corr_pulse == 1'b1, "R6 register limit exceeded", int'(corr_pulse), 1);
      for (int i = 0; i < 511; i++) cycle(1'b1, 1'b0);
      check(oos_flag == 1'b1, "R6 R2 register window 512 pending", int'(oos_flag), 1);
      cycle(1'b1, 1'b0);
      check(oos_flag == 1'b0, "R6 R2 register window 512 complete", int'(oos_flag), 0);
      // R6: pins selected
      ext_sel = 1'b1; pin_win = 8'd0; pin_thr = 8'd0;
      for (int i = 0; i < 7; i++) cycle(1'b0, 1'b1);
      check(corr_pulse == 1'b1, "R6 pin limit 6 exceeded", int'(corr_pulse), 1);

      // random segments
      for (int seg = 0; seg < 60; seg++) begin
         int p_vld, p_stb;
         ext_sel = 1'($urandom_range(0, 1));
         pin_win = 8'($urandom_range(0, 3));
         pin_thr = 8'($urandom_range(0, 4));
         if ($urandom_range(0, 3) == 0) host_write(1'($urandom_range(0, 1)), $urandom_range(0, 3));
         p_vld = $urandom_range(40, 100);
         p_stb = $urandom_range(0, 6);
         for (int c = 0; c < 1500; c++)
            cycle(($urandom_range(0, 99) < p_vld), ($urandom_range(0, 99) < p_stb));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule